// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns a parallel data word into an asynchronous serial frame on a single output line. A frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. All bit timing comes from a one-cycle enable, `tick16`, which an external rate generator pulses at sixteen times the bit rate. Each bit lasts sixteen of these enables.

The transmitter is double buffered. A host write fills a holding register. That word moves into the shifter on the first clock on which the shifter is idle, so the host can queue the next word while the current frame is still on the line. Two flags report progress: `thr_empty` shows that the holding register can take a word, and `tx_empty` shows that nothing is queued and the last stop period has ended. A break input pulls the line low at once and keeps it low for as long as it stays asserted.

The word length, parity and stop settings are sampled when a word moves into the shifter. Changing them during a frame therefore affects only later frames.

Top module: `async_tx`

## Requirements
- R1: While reset is asserted and directly after it, `txd` is 1 and both `thr_empty` and `tx_empty` are 1.
- R2: A frame starts with `txd` low for 16 ticks. The data bits follow, least significant bit first, each lasting 16 ticks. `word_len` selects the bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are never sent.
- R3: When `par_en` is 1, one parity bit of 16 ticks follows the data. With `par_even` at 1 the count of ones across the sent data bits and the parity bit is even. With `par_even` at 0 that count is odd.
- R4: The stop period is high. With `stop_sel` at 0 it lasts 16 ticks. With `stop_sel` at 1 it lasts 24 ticks when `word_len` is 0 and 32 ticks otherwise. `tx_empty` rises on the clock that ends the stop period.
- R5: Frame timing advances only on clock cycles where `tick16` is 1. With `tick16` held low, `txd` holds its level.
- R6: A write (`wr_en`) clears `thr_empty` on the next clock. When the shifter is idle, the word moves into it on the following clock. On that clock `thr_empty` returns to 1 and the start bit begins.
- R7: A word written while a frame is being sent waits in the holding register. Its start bit begins one clock after the current stop period ends, and `tx_empty` stays 0 throughout.
- R8: `tx_empty` is 1 only when the holding register is empty and the shifter is idle. The line is high whenever `tx_empty` is 1.
- R9: While `brk` is 1, `txd` is 0 in the same cycle, whatever the state of the shifter. The frame timing keeps running underneath, so releasing `brk` shows the bit that is due at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word to send |
| word_len | input | 2 | Data bits minus 5 |
| stop_sel | input | 1 | 0: one stop bit; 1: 1.5 stop bits (5-bit words) or 2 stop bits |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output, idles high |
| thr_empty | output | 1 | Holding register can take a word |
| tx_empty | output | 1 | Holding register and shifter are both empty |

## Verification
The assertions are checked on every clock:
- the flag changes caused by a write or a transfer;
- a low line directly after each transfer;
- a steady line on cycles without a tick;
- `tx_empty` rising only at the end of a stop period;
- a high line whenever the block is empty.

Some behaviour can only be shown by the bench scenarios:
- the bit order;
- the masking of data to the selected word length;
- the parity value;
- the exact stop lengths, including the 24-tick case;
- back-to-back frames;
- break asserted in the middle of a frame.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

  // Number of data bits for a word-length code.
  function automatic int data_bits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  // Stop period length in ticks.
  function automatic int stop_ticks(input int ovs, input logic [1:0] len,
                                    input logic stop_sel);
    if (!stop_sel)          return ovs;
    else if (len == 2'd0)   return (ovs * 3) / 2;
    else                    return ovs * 2;
  endfunction

  // Parity over the bits that are actually sent.
  function automatic logic parity_bit(input logic [DATA_W-1:0] d,
                                      input logic [1:0] len,
                                      input logic even);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < data_bits(len)) acc = acc ^ d[i];
    return even ? acc : ~acc;
  endfunction

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en) begin
      data <= wr_data;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        word_len,
  input  logic              stop_sel,
  input  logic              par_en,
  input  logic              par_even,
  output logic              busy,
  output logic              line,
  output logic              frame_done
);

  localparam int CNT_W = $clog2(2 * OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

  tx_state_t         state;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bidx;
  logic [1:0]        len_q;
  logic              stop_q;
  logic              pen_q;
  logic              pbit_q;

  logic [CNT_W-1:0]  stop_last;
  logic [IDX_W-1:0]  data_last;
  logic              bit_end;

  assign stop_last  = CNT_W'(stop_ticks(OVS, len_q, stop_q) - 1);
  assign data_last  = IDX_W'(data_bits(len_q) - 1);
  assign bit_end    = tick && (cnt == BIT_LAST);
  assign frame_done = (state == ST_STOP) && tick && (cnt == stop_last);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh[0];
      ST_PAR:   line = pbit_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sh     <= '0;
      cnt    <= '0;
      bidx   <= '0;
      len_q  <= '0;
      stop_q <= 1'b0;
      pen_q  <= 1'b0;
      pbit_q <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (load) begin
        state  <= ST_START;
        sh     <= ld_data;
        cnt    <= '0;
        bidx   <= '0;
        len_q  <= word_len;
        stop_q <= stop_sel;
        pen_q  <= par_en;
        pbit_q <= parity_bit(ld_data, word_len, par_even);
      end
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      case (state)
        ST_START: if (bit_end) begin
          state <= ST_DATA;
          cnt   <= '0;
        end
        ST_DATA: if (bit_end) begin
          cnt <= '0;
          sh  <= sh >> 1;
          if (bidx == data_last) state <= pen_q ? ST_PAR : ST_STOP;
          else                   bidx  <= bidx + 1'b1;
        end
        ST_PAR: if (bit_end) begin
          state <= ST_STOP;
          cnt   <= '0;
        end
        ST_STOP: if (frame_done) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        word_len,
  input  logic              stop_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              brk,
  output logic              txd,
  output logic              thr_empty,
  output logic              tx_empty
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              line_raw;
  logic              frame_done;
  logic              xfer;

  assign xfer = hold_full && !busy;

  async_tx_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (xfer),
    .full    (hold_full),
    .data    (hold_data)
  );

  async_tx_shift #(.OVS(OVS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .load       (xfer),
    .ld_data    (hold_data),
    .word_len   (word_len),
    .stop_sel   (stop_sel),
    .par_en     (par_en),
    .par_even   (par_even),
    .busy       (busy),
    .line       (line_raw),
    .frame_done (frame_done)
  );

  assign txd       = brk ? 1'b0 : line_raw;
  assign thr_empty = !hold_full;
  assign tx_empty  = !hold_full && !busy;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic wr_en,
  input logic xfer,
  input logic line_raw,
  input logic frame_done,
  input logic thr_empty,
  input logic tx_empty
);

  // R6
  wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thr_empty);

  // R6
  xfer_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_en) |=> thr_empty);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !line_raw);

  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !xfer) |=> $stable(line_raw));

  // R4
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(frame_done));

  // R8
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> line_raw);

endmodule

bind async_tx async_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick16     (tick16),
  .wr_en      (wr_en),
  .xfer       (xfer),
  .line_raw   (line_raw),
  .frame_done (frame_done),
  .thr_empty  (thr_empty),
  .tx_empty   (tx_empty)
);

// File: tb/async_tx_tb.sv
module async_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_on = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] word_len = '0;
  logic       stop_sel = 1'b0;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       brk = 1'b0;
  logic       txd, thr_empty, tx_empty;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  async_tx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick_on),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .word_len  (word_len),
    .stop_sel  (stop_sel),
    .par_en    (par_en),
    .par_even  (par_even),
    .brk       (brk),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty)
  );

  // {data[12:5], word_len[4:3], stop_sel[2], par_en[1], par_even[0]}
  localparam logic [12:0] VEC [0:7] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 1'b1, 1'b1},
    {8'h1B, 2'd0, 1'b1, 1'b1, 1'b0},
    {8'hFF, 2'd1, 1'b1, 1'b0, 1'b0},
    {8'h55, 2'd2, 1'b0, 1'b1, 1'b1},
    {8'h80, 2'd2, 1'b0, 1'b1, 1'b0},
    {8'h01, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'hFE, 2'd3, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected line level for bit slot k (0 = start).
  function automatic int exp_bit(input int k, input logic [7:0] d, input int nb,
                                 input logic pen, input logic peven);
    int ones;
    if (k == 0) return 0;
    if (k <= nb) return int'(d[k-1]);
    if (pen && k == nb + 1) begin
      ones = 0;
      for (int i = 0; i < nb; i++) ones += int'(d[i]);
      return peven ? (ones % 2) : 1 - (ones % 2);
    end
    return 1;
  endfunction

  function automatic int exp_stop(input logic [1:0] len, input logic ss);
    if (!ss) return 16;
    return (len == 2'd0) ? 24 : 32;
  endfunction

  // Write a word; returns at the negedge where its start bit is visible.
  task automatic put(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6", "thr_empty after write", int'(thr_empty), 0);
    @(negedge clk);
    chk("R6", "thr_empty after transfer", int'(thr_empty), 1);
    chk("R2", "start bit", int'(txd), 0);
  endtask

  // Called at the negedge where the start bit begins (index 0).
  task automatic check_frame(input logic [7:0] d, input logic [1:0] len, input logic ss,
                             input logic pen, input logic peven, input bit want_empty,
                             input int brk_on, input int brk_off);
    int nb, body, total, k;
    nb = 5 + int'(len);
    body = (1 + nb + int'(pen)) * 16;
    total = body + exp_stop(len, ss);
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      if (i == brk_on) begin
        brk = 1'b1; #1;
        chk("R9", "break forces low", int'(txd), 0);
      end
      if (i == brk_off) begin
        chk("R9", "break held low", int'(txd), 0);
        brk = 1'b0; #1;
        k = i / 16;
        chk("R9", "bit after break release", int'(txd), exp_bit(k, d, nb, pen, peven));
      end
      if (!brk && (i % 16) == 8 && i <= body + 8) begin
        k = i / 16;
        if (k == 0)           chk("R2", "start mid", int'(txd), 0);
        else if (k <= nb)     chk("R2", "data bit", int'(txd), exp_bit(k, d, nb, pen, peven));
        else if (pen && k == nb + 1)
                              chk("R3", "parity bit", int'(txd), exp_bit(k, d, nb, pen, peven));
        else                  chk("R4", "stop level", int'(txd), 1);
      end
      if (want_empty && i == total - 1) chk("R4", "tx_empty before stop end", int'(tx_empty), 0);
      if (want_empty && i == total)     chk("R4", "tx_empty at stop end", int'(tx_empty), 1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt_wait, tot_a;
    bit stayed_low;
    repeat (3) @(negedge clk);
    chk("R1", "txd in reset", int'(txd), 1);
    chk("R1", "thr_empty in reset", int'(thr_empty), 1);
    chk("R1", "tx_empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "txd after reset", int'(txd), 1);
    chk("R8", "tx_empty after reset", int'(tx_empty), 1);

    // Table of frame settings
    for (int v = 0; v < 8; v++) begin
      word_len = VEC[v][4:3]; stop_sel = VEC[v][2];
      par_en = VEC[v][1]; par_even = VEC[v][0];
      put(VEC[v][12:5]);
      check_frame(VEC[v][12:5], VEC[v][4:3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b1, -1, -1);
      @(negedge clk);
    end

    // R9: break on an idle line
    brk = 1'b1; #1;
    chk("R9", "break on idle", int'(txd), 0);
    chk("R8", "tx_empty during idle break", int'(tx_empty), 1);
    @(negedge clk);
    brk = 1'b0; #1;
    chk("R9", "idle after break", int'(txd), 1);

    // R9: break in mid frame, timing unaffected
    word_len = 2'd3; stop_sel = 1'b0; par_en = 1'b0; par_even = 1'b0;
    @(negedge clk);
    put(8'hFF);
    check_frame(8'hFF, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 40, 70);
    @(negedge clk);

    // R5: ticks withheld during the start bit
    word_len = 2'd2; stop_sel = 1'b1; par_en = 1'b1; par_even = 1'b1;
    put(8'h6D);
    tick_on = 1'b0;
    repeat (60) @(negedge clk);
    chk("R5", "line held without ticks", int'(txd), 0);
    chk("R5", "tx_empty held without ticks", int'(tx_empty), 0);
    tick_on = 1'b1;
    check_frame(8'h6D, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, -1, -1);
    @(negedge clk);

    // R7: back-to-back words
    word_len = 2'd0; stop_sel = 1'b0; par_en = 1'b0; par_even = 1'b0;
    put(8'h15);
    wr_en = 1'b1; wr_data = 8'h0A;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7", "queued word holds register", int'(thr_empty), 0);
    tot_a = (1 + 5) * 16 + 16;
    cnt_wait = 1; stayed_low = 1;
    while (!thr_empty && cnt_wait < 1000) begin
      if (tx_empty) stayed_low = 0;
      if (cnt_wait == 8 + 16 * 3) chk("R7", "first word bit 2", int'(txd), 1);
      @(negedge clk);
      cnt_wait++;
    end
    chk("R7", "second start clock", cnt_wait, tot_a + 1);
    chk("R7", "tx_empty stayed low", int'(stayed_low), 1);
    chk("R7", "second start bit", int'(txd), 0);
    check_frame(8'h0A, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, -1, -1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule